// File: doc/BRIEF.md
# Display RAM Address Pointer

This block tracks the column pointer (X) and bank pointer (Y) for a display memory with 102 columns and 9 banks, where each bank is one byte high except the last, which is a single row. After each byte access it moves the pointer on. In horizontal order the column runs first. In vertical order the bank runs first. Both orders wrap at the non-power-of-two limits 101 and 8. A read-modify-write setting stops reads from moving the pointer, so a host can read a byte and then write it back to the same place.

Software-style loads place the pointer directly, and a load value outside the legal range is dropped. The block also turns the logical column into a physical column when horizontal mirroring is on. From the result it forms a linear RAM address and a byte write mask for the memory next to it. The memory array and the refresh readout sit outside this block.

Top module: `dram_addr_ptr`

## Requirements
- R1: After reset (rstN low), ptrX = 0, ptrY = 0 and ramAddr = 0.
- R2: In horizontal order (vertMode = 0), an advancing access raises ptrX by one. When ptrX is 101, ptrX returns to 0 and ptrY advances, wrapping from 8 to 0.
- R3: In vertical order (vertMode = 1), an advancing access raises ptrY by one. When ptrY is 8, ptrY returns to 0 and ptrX advances, wrapping from 101 to 0.
- R4: An advancing access at ptrX = 101, ptrY = 8 leaves both pointers at 0 in either order.
- R5: A write strobe always advances the pointer. A read strobe advances it only when rmwMode = 0. With rmwMode = 1, a lone read leaves both pointers unchanged.
- R6: setXValid or setYValid loads the matching in-range value at the next clock edge. In a cycle with any load strobe, the access strobes cause no advance.
- R7: A load whose value is out of range (X above 101, Y above 8) is ignored and leaves both pointers unchanged.
- R8: physCol equals ptrX when mirrorX = 0 and equals 101 − ptrX when mirrorX = 1. It follows mirrorX in the same cycle.
- R9: ramAddr equals ptrY × 102 + physCol, computed combinationally from the current pointers.
- R10: wrMask is 8'hFF for banks 0 to 7 and 8'h80 (bit 7 only) when ptrY = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setXValid | input | 1 | Load strobe for the column pointer |
| setXValue | input | 7 | Column value to load |
| setYValid | input | 1 | Load strobe for the bank pointer |
| setYValue | input | 4 | Bank value to load |
| rdStrobe | input | 1 | One byte read this cycle |
| wrStrobe | input | 1 | One byte written this cycle |
| vertMode | input | 1 | 1 = bank-first (vertical) order, 0 = column-first |
| rmwMode | input | 1 | 1 = reads do not advance the pointer |
| mirrorX | input | 1 | 1 = logical column 0 maps to physical column 101 |
| ptrX | output | 7 | Logical column pointer |
| ptrY | output | 4 | Bank pointer |
| physCol | output | 7 | Physical column after mirroring |
| ramAddr | output | 10 | Linear RAM address |
| wrMask | output | 8 | Byte lanes stored by a write at the current bank |

## Verification
The corner at column 101 of bank 8 is the hardest state to reach. From reset it takes 917 advancing accesses in one order, and random loads seldom land on it with a write in the next cycle. The stimulus reaches it in two ways. A directed load places the pointer on the corner before a write in each order. Two full 918-write sweeps, one per order, must bring the pointer back to the origin exactly once. Random traffic then mixes out-of-range loads, loads that collide with accesses, and read-modify-write reads.

// File: rtl/dram_ptr_pkg.sv
package dram_ptr_pkg;

  // Strobes from the control half to the pointer datapath
  typedef struct packed {
    logic loadX;     // in-range column load
    logic loadY;     // in-range bank load
    logic advance;   // move the pointer by one byte
    logic vertical;  // bank-first order for this advance
  } ptr_ctl_t;

endpackage

// File: rtl/dram_ptr_ctrl.sv
module dram_ptr_ctrl
  import dram_ptr_pkg::*;
#(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  localparam int XW = $clog2(NUM_COLS),
  localparam int YW = $clog2(NUM_BANKS)
) (
  input  logic          setXValid,
  input  logic [XW-1:0] setXValue,
  input  logic          setYValid,
  input  logic [YW-1:0] setYValue,
  input  logic          rdStrobe,
  input  logic          wrStrobe,
  input  logic          vertMode,
  input  logic          rmwMode,
  output ptr_ctl_t      ctl
);

  localparam logic [XW-1:0] LAST_X = XW'(NUM_COLS - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(NUM_BANKS - 1);

  logic anyLoad;
  logic accessCounts;

  // Any load strobe, legal or not, claims the cycle (R6)
  assign anyLoad = setXValid | setYValid;

  // Reads count only outside read-modify-write mode (R5)
  assign accessCounts = wrStrobe | (rdStrobe & ~rmwMode);

  always_comb begin
    ctl          = '0;
    ctl.loadX    = setXValid & (setXValue <= LAST_X);  // R7
    ctl.loadY    = setYValid & (setYValue <= LAST_Y);  // R7
    ctl.advance  = accessCounts & ~anyLoad;
    ctl.vertical = vertMode;
  end

endmodule

// File: rtl/dram_ptr_datapath.sv
module dram_ptr_datapath
  import dram_ptr_pkg::*;
#(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  parameter int BYTE_W    = 8,
  localparam int XW = $clog2(NUM_COLS),
  localparam int YW = $clog2(NUM_BANKS),
  localparam int AW = $clog2(NUM_COLS * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptr_ctl_t          ctl,
  input  logic [XW-1:0]     setXValue,
  input  logic [YW-1:0]     setYValue,
  input  logic              mirrorX,
  output logic [XW-1:0]     ptrX,
  output logic [YW-1:0]     ptrY,
  output logic [XW-1:0]     physCol,
  output logic [AW-1:0]     ramAddr,
  output logic [BYTE_W-1:0] wrMask
);

  localparam logic [XW-1:0] LAST_X = XW'(NUM_COLS - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(NUM_BANKS - 1);

  logic [XW-1:0] xQ, xD, xInc;
  logic [YW-1:0] yQ, yD, yInc;
  logic          xAtEnd, yAtEnd;

  assign xAtEnd = (xQ == LAST_X);
  assign yAtEnd = (yQ == LAST_Y);
  assign xInc   = xAtEnd ? '0 : xQ + XW'(1);
  assign yInc   = yAtEnd ? '0 : yQ + YW'(1);

  // Next-pointer selection: loads, then one of the two orders (R2, R3, R4)
  always_comb begin
    xD = xQ;
    yD = yQ;
    if (ctl.loadX || ctl.loadY) begin
      if (ctl.loadX) xD = setXValue;
      if (ctl.loadY) yD = setYValue;
    end else if (ctl.advance) begin
      if (ctl.vertical) begin
        yD = yInc;
        if (yAtEnd) xD = xInc;
      end else begin
        xD = xInc;
        if (xAtEnd) yD = yInc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xQ <= '0;
      yQ <= '0;
    end else begin
      xQ <= xD;
      yQ <= yD;
    end
  end

  assign ptrX = xQ;
  assign ptrY = yQ;

  // Column mirroring (R8)
  assign physCol = mirrorX ? (LAST_X - xQ) : xQ;

  // Linear address (R9): concatenate when the column count is a power of two
  generate
    if (NUM_COLS == (1 << XW)) begin : g_addrConcat
      assign ramAddr = AW'({yQ, physCol});
    end else begin : g_addrMul
      assign ramAddr = AW'(yQ) * AW'(NUM_COLS) + AW'(physCol);
    end
  endgenerate

  // The last bank stores only the top bit of a byte (R10)
  assign wrMask = yAtEnd ? {1'b1, {(BYTE_W-1){1'b0}}} : {BYTE_W{1'b1}};

endmodule

// File: rtl/dram_addr_ptr.sv
module dram_addr_ptr
  import dram_ptr_pkg::*;
#(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  parameter int BYTE_W    = 8,
  localparam int XW = $clog2(NUM_COLS),
  localparam int YW = $clog2(NUM_BANKS),
  localparam int AW = $clog2(NUM_COLS * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setXValid,
  input  logic [XW-1:0]     setXValue,
  input  logic              setYValid,
  input  logic [YW-1:0]     setYValue,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              vertMode,
  input  logic              rmwMode,
  input  logic              mirrorX,
  output logic [XW-1:0]     ptrX,
  output logic [YW-1:0]     ptrY,
  output logic [XW-1:0]     physCol,
  output logic [AW-1:0]     ramAddr,
  output logic [BYTE_W-1:0] wrMask
);

  ptr_ctl_t ctl;

  dram_ptr_ctrl #(
    .NUM_COLS (NUM_COLS),
    .NUM_BANKS(NUM_BANKS)
  ) u_ctrl (
    .setXValid(setXValid),
    .setXValue(setXValue),
    .setYValid(setYValid),
    .setYValue(setYValue),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .vertMode (vertMode),
    .rmwMode  (rmwMode),
    .ctl      (ctl)
  );

  dram_ptr_datapath #(
    .NUM_COLS (NUM_COLS),
    .NUM_BANKS(NUM_BANKS),
    .BYTE_W   (BYTE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .setXValue(setXValue),
    .setYValue(setYValue),
    .mirrorX  (mirrorX),
    .ptrX     (ptrX),
    .ptrY     (ptrY),
    .physCol  (physCol),
    .ramAddr  (ramAddr),
    .wrMask   (wrMask)
  );

endmodule

// File: rtl/dram_addr_ptr_checker.sv
module dram_addr_ptr_checker #(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  parameter int BYTE_W    = 8,
  localparam int XW = $clog2(NUM_COLS),
  localparam int YW = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              setXValid,
  input logic [XW-1:0]     setXValue,
  input logic              setYValid,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic              vertMode,
  input logic              rmwMode,
  input logic [XW-1:0]     ptrX,
  input logic [YW-1:0]     ptrY,
  input logic [BYTE_W-1:0] wrMask
);

  localparam logic [XW-1:0] LAST_X = XW'(NUM_COLS - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(NUM_BANKS - 1);

  logic stepNow;
  assign stepNow = !setXValid && !setYValid && (wrStrobe || (rdStrobe && !rmwMode));

  a_r2_x_range: assert property (@(posedge clk) disable iff (!rstN)
    ptrX <= LAST_X && ptrY <= LAST_Y);

  a_r2_h_step: assert property (@(posedge clk) disable iff (!rstN)
    stepNow && !vertMode && ptrX != LAST_X |=>
      ptrX == $past(ptrX) + XW'(1) && ptrY == $past(ptrY));

  a_r2_h_wrap: assert property (@(posedge clk) disable iff (!rstN)
    stepNow && !vertMode && ptrX == LAST_X |=> ptrX == '0);

  a_r3_v_step: assert property (@(posedge clk) disable iff (!rstN)
    stepNow && vertMode && ptrY != LAST_Y |=>
      ptrY == $past(ptrY) + YW'(1) && ptrX == $past(ptrX));

  a_r3_v_wrap: assert property (@(posedge clk) disable iff (!rstN)
    stepNow && vertMode && ptrY == LAST_Y |=> ptrY == '0);

  a_r4_corner: assert property (@(posedge clk) disable iff (!rstN)
    stepNow && ptrX == LAST_X && ptrY == LAST_Y |=> ptrX == '0 && ptrY == '0);

  a_r5_rmw_hold: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !wrStrobe && rmwMode && !setXValid && !setYValid |=>
      $stable(ptrX) && $stable(ptrY));

  a_r7_bad_x: assert property (@(posedge clk) disable iff (!rstN)
    setXValid && setXValue > LAST_X && !setYValid |=>
      $stable(ptrX) && $stable(ptrY));

  a_r10_last_mask: assert property (@(posedge clk) disable iff (!rstN)
    ptrY == LAST_Y |-> wrMask[BYTE_W-1] && $countones(wrMask) == 1);

endmodule

bind dram_addr_ptr dram_addr_ptr_checker #(
  .NUM_COLS (NUM_COLS),
  .NUM_BANKS(NUM_BANKS),
  .BYTE_W   (BYTE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .setXValid(setXValid),
  .setXValue(setXValue),
  .setYValid(setYValid),
  .rdStrobe (rdStrobe),
  .wrStrobe (wrStrobe),
  .vertMode (vertMode),
  .rmwMode  (rmwMode),
  .ptrX     (ptrX),
  .ptrY     (ptrY),
  .wrMask   (wrMask)
);

// File: tb/dram_addr_ptr_test.sv
module dram_addr_ptr_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       setXValid = 1'b0;
  logic [6:0] setXValue = '0;
  logic       setYValid = 1'b0;
  logic [3:0] setYValue = '0;
  logic       rdStrobe = 1'b0;
  logic       wrStrobe = 1'b0;
  logic       vertMode = 1'b0;
  logic       rmwMode = 1'b0;
  logic       mirrorX = 1'b0;
  logic [6:0] ptrX;
  logic [3:0] ptrY;
  logic [6:0] physCol;
  logic [9:0] ramAddr;
  logic [7:0] wrMask;

  int checks = 0;
  int errors = 0;
  int mX = 0;
  int mY = 0;
  int mMir = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dram_addr_ptr uut (
    .clk(clk), .rstN(rstN),
    .setXValid(setXValid), .setXValue(setXValue),
    .setYValid(setYValid), .setYValue(setYValue),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .vertMode(vertMode), .rmwMode(rmwMode), .mirrorX(mirrorX),
    .ptrX(ptrX), .ptrY(ptrY), .physCol(physCol),
    .ramAddr(ramAddr), .wrMask(wrMask)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPhys(input int x, input int mir);
    return mir != 0 ? 101 - x : x;
  endfunction

  // Expected next pointer from the requirements
  task automatic modelStep(input bit sx, input int xv, input bit sy, input int yv,
                           input bit rd, input bit wr, input bit v, input bit rm);
    if (sx || sy) begin
      if (sx && xv <= 101) mX = xv;
      if (sy && yv <= 8)   mY = yv;
    end else if (wr || (rd && !rm)) begin
      if (!v) begin
        if (mX == 101) begin mX = 0; mY = (mY == 8) ? 0 : mY + 1; end
        else mX = mX + 1;
      end else begin
        if (mY == 8) begin mY = 0; mX = (mX == 101) ? 0 : mX + 1; end
        else mY = mY + 1;
      end
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic drive(input bit sx, input int xv, input bit sy, input int yv,
                       input bit rd, input bit wr, input bit v, input bit rm,
                       input bit mx);
    setXValid = sx; setXValue = 7'(xv);
    setYValid = sy; setYValue = 4'(yv);
    rdStrobe = rd; wrStrobe = wr;
    vertMode = v; rmwMode = rm; mirrorX = mx;
    mMir = int'(mx);
    modelStep(sx, xv, sy, yv, rd, wr, v, rm);
    @(negedge clk);
    setXValid = 1'b0; setYValid = 1'b0; rdStrobe = 1'b0; wrStrobe = 1'b0;
  endtask

  task automatic chkPtr(input string req);
    chk(req, int'(ptrX), mX);
    chk(req, int'(ptrY), mY);
  endtask

  task automatic chkAll(input string req);
    chkPtr(req);
    chk("R8", int'(physCol), expPhys(mX, mMir));
    chk("R9", int'(ramAddr), mY * 102 + expPhys(mX, mMir));
    chk("R10", int'(wrMask), (mY == 8) ? 8'h80 : 8'hFF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int wraps;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1", int'(ptrX), 0);
    chk("R1", int'(ptrY), 0);
    chk("R1", int'(ramAddr), 0);
    chk("R10", int'(wrMask), 8'hFF);

    // R6: in-range load, then R8/R9 mapping with and without mirror
    drive(1, 5, 1, 3, 0, 0, 0, 0, 0);
    chkAll("R6");
    chk("R9", int'(ramAddr), 311);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", int'(physCol), 96);
    chk("R9", int'(ramAddr), 402);

    // R7: out-of-range loads ignored
    drive(1, 120, 0, 0, 0, 0, 0, 0, 0);
    chkPtr("R7");
    drive(0, 0, 1, 12, 0, 0, 0, 0, 0);
    chkPtr("R7");
    chk("R7", int'(ptrY), 3);
    drive(1, 102, 1, 9, 1, 1, 0, 0, 0);
    chk("R7", int'(ptrX), 5);
    chk("R7", int'(ptrY), 3);

    // R6: load cycle blocks the access advance
    drive(1, 10, 0, 0, 0, 1, 0, 0, 0);
    chk("R6", int'(ptrX), 10);
    chk("R6", int'(ptrY), 3);

    // R2: horizontal step and row wrap
    drive(1, 100, 1, 2, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2", int'(ptrX), 101);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2", int'(ptrX), 0);
    chk("R2", int'(ptrY), 3);

    // R3: vertical step and column advance on bank wrap
    drive(1, 4, 1, 7, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R3", int'(ptrY), 8);
    chk("R10", int'(wrMask), 8'h80);
    drive(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R3", int'(ptrY), 0);
    chk("R3", int'(ptrX), 5);

    // R4: last-corner wrap in both orders
    drive(1, 101, 1, 8, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4", int'(ptrX), 0);
    chk("R4", int'(ptrY), 0);
    drive(1, 101, 1, 8, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R4", int'(ptrX), 0);
    chk("R4", int'(ptrY), 0);

    // R5: read-modify-write behaviour
    drive(1, 20, 1, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 1, 0);
    chk("R5", int'(ptrX), 20);
    drive(0, 0, 0, 0, 0, 1, 0, 1, 0);
    chk("R5", int'(ptrX), 21);
    drive(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5", int'(ptrX), 22);

    // R2/R4: full horizontal sweep returns to origin exactly once
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0);
    wraps = 0;
    for (int i = 0; i < 918; i++) begin
      drive(0, 0, 0, 0, 0, 1, 0, 0, 0);
      if (ptrX == 0 && ptrY == 0) wraps++;
    end
    chk("R2", wraps, 1);
    chkPtr("R4");
    // R3/R4: full vertical sweep
    wraps = 0;
    for (int i = 0; i < 918; i++) begin
      drive(0, 0, 0, 0, 0, 1, 1, 0, 0);
      if (ptrX == 0 && ptrY == 0) wraps++;
    end
    chk("R3", wraps, 1);
    chkPtr("R4");

    // Random traffic against the model (R2 R3 R5 R6 R7 R8 R9 R10)
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      bit sx, sy;
      sx = ($urandom % 16) == 0;
      sy = ($urandom % 16) == 0;
      drive(sx, int'($urandom % 128), sy, int'($urandom % 16),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      chkAll("R2/R3/R5/R6/R7");
    end

    // R1: reset again from a non-zero state
    drive(1, 50, 1, 6, 0, 0, 0, 0, 0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1", int'(ptrX), 0);
    chk("R1", int'(ptrY), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule